// File: doc/BRIEF.md
# Configurable UART Line Receiver

This block turns an asynchronous serial receive line into data words. The word length, the parity mode and the stop-time rule all come from a six-bit line-control value. The transmitter on the same chip uses the same value. The line is resynchronised to the core clock first. It is then sampled at the middle of each bit, counted in ticks of a 16x oversampling enable supplied from outside. Data bits arrive least significant bit first.

Each received frame produces a one-cycle strobe. The strobe comes with the data word, zero-extended to eight bits, and with three flags: parity error, framing error and line break. The value of the received parity bit is also given. In forced-parity (multidrop) operation this bit tells an address word from a data word. A low pulse that has ended by the middle of the start bit is discarded. After a break, the receiver stays quiet until the line returns high.

Top module: `uart_line_rx`

## Requirements
- R1: Control bits [1:0] set the data length (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits). Bits are collected least significant first, and the unused upper bits of the output word are zero.
- R2: With control bit 3 clear, no parity slot is expected: the stop bit follows the last data bit directly, and the parity-error flag and the parity-bit output are 0.
- R3: With control bit 3 set and bit 5 clear, the parity bit is checked as even parity when control bit 4 is 1 and as odd parity when it is 0. A mismatch sets the parity-error flag.
- R4: With control bits 3 and 5 both set, the expected parity bit is the inverse of control bit 4. The parity-bit output carries the received parity value.
- R5: A start bit is accepted only if the line is still low 8 ticks after the falling edge is seen. Otherwise no word is produced.
- R6: A low line at the middle of the first stop bit sets the framing-error flag for that word.
- R7: For 5-bit words with control bit 2 set, the line must also be high 12 ticks after the first stop sample (1.25 bit times into the stop). A stop time of 1.5 bits passes, and a 1-bit stop followed by a low line is a framing error.
- R8: For 6- to 8-bit words, control bit 2 does not lengthen the checked stop time. Frames sent back to back with one stop bit are each received without error.
- R9: If every data, parity and stop sample of a frame is low, the word is reported with the break and framing-error flags set, data 0 and parity error 0. No further word is reported until the line has gone high.
- R10: The valid strobe lasts one clock. The data and flag outputs are zero whenever the strobe is low.
- R11: The line passes through a two-flop synchronizer, reset to the idle-high level. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial receive line |
| tick_i | input | 1 | One-clock enable, 16 per bit time |
| lcr_i | input | 6 | Line control: [1:0] length, [2] long stop, [3] parity enable, [4] even, [5] forced |
| rx_valid_o | output | 1 | One-cycle strobe for a finished frame |
| rx_data_o | output | 8 | Received word, zero-extended |
| parity_err_o | output | 1 | Parity mismatch for this word |
| frame_err_o | output | 1 | Stop bit found low |
| break_o | output | 1 | All-zero frame including stop |
| parity_bit_o | output | 1 | Received parity bit value (0 without parity) |

## Verification
The strobe and its flags are due one clock after the tick that takes the deciding stop sample. That sample falls 8 ticks into the first stop bit, or 20 ticks in for a 5-bit word with the long stop. On top of this come two clocks of synchronizer delay and up to one tick of start-edge detection. Each scenario task therefore drives a full frame followed by at least 32 ticks of idle line before it reads what a monitor captured at falling clock edges. The monitor also counts strobes, so a missing, doubled or early-dropped word, or a word from a rejected glitch, shows up as a wrong count. Strobe width and flag quietness are tracked on every cycle and checked at the end.

// File: rtl/uart_lrx_pkg.sv
package uart_lrx_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic       par_force;
        logic       par_even;
        logic       par_en;
        logic       long_stop;
        logic [1:0] len;
    } rx_cfg_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              par_err;
        logic              frm_err;
        logic              brk;
        logic              par_bit;
    } rx_result_t;

    function automatic rx_cfg_t decode_lcr(input logic [5:0] v);
        rx_cfg_t c;
        c.len       = v[1:0];
        c.long_stop = v[2];
        c.par_en    = v[3];
        c.par_even  = v[4];
        c.par_force = v[5];
        return c;
    endfunction

    // index of the last data bit: 4..7 for 5..8 bit words
    function automatic logic [2:0] last_bit_idx(input logic [1:0] len);
        return {1'b0, len} + 3'd4;
    endfunction

endpackage

// File: rtl/uart_lrx_sync.sv
module uart_lrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_lrx_parity.sv
module uart_lrx_parity
    import uart_lrx_pkg::*;
(
    input  logic              par_en_i,
    input  logic              par_even_i,
    input  logic              par_force_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              rx_par_i,
    output logic              par_err_o
);
    logic ones_odd;
    logic expect_bit;

    always_comb begin
        ones_odd = ^data_i;
        if (par_force_i) begin
            expect_bit = ~par_even_i;
        end else if (par_even_i) begin
            expect_bit = ones_odd;
        end else begin
            expect_bit = ~ones_odd;
        end
        par_err_o = par_en_i & (rx_par_i != expect_bit);
    end
endmodule

// File: rtl/uart_lrx_fsm.sv
module uart_lrx_fsm
    import uart_lrx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       rx_s_i,
    input  logic [5:0] lcr_i,
    output logic       valid_o,
    output rx_result_t res_o
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
    localparam logic [CW-1:0] LONG_CNT = CW'((OSR * 3) / 4 - 1);

    rx_state_e         state_q;
    logic [CW-1:0]     cnt_q;
    logic [2:0]        idx_q;
    logic [WORD_W-1:0] shreg_q;
    rx_cfg_t           cfg_q;
    logic              par_q;
    logic              all_low_q;
    logic              valid_q;
    rx_result_t        res_q;
    logic              perr_w;

    uart_lrx_parity u_par (
        .par_en_i   (cfg_q.par_en),
        .par_even_i (cfg_q.par_even),
        .par_force_i(cfg_q.par_force),
        .data_i     (shreg_q),
        .rx_par_i   (par_q),
        .par_err_o  (perr_w)
    );

    logic sample_pt;
    always_comb begin
        unique case (state_q)
            ST_START: sample_pt = tick_i && (cnt_q == MID_CNT);
            ST_STOP2: sample_pt = tick_i && (cnt_q == LONG_CNT);
            default:  sample_pt = tick_i && (cnt_q == LAST_CNT);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            shreg_q   <= '0;
            cfg_q     <= '0;
            par_q     <= 1'b0;
            all_low_q <= 1'b0;
            valid_q   <= 1'b0;
            res_q     <= '0;
        end else begin
            valid_q <= 1'b0;
            res_q   <= '0;
            if (tick_i && state_q != ST_IDLE && state_q != ST_HOLD) begin
                cnt_q <= sample_pt ? '0 : cnt_q + 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (tick_i && !rx_s_i) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                    end
                end
                ST_START: begin
                    if (sample_pt) begin
                        if (!rx_s_i) begin
                            state_q   <= ST_DATA;
                            idx_q     <= '0;
                            shreg_q   <= '0;
                            par_q     <= 1'b0;
                            all_low_q <= 1'b1;
                            cfg_q     <= decode_lcr(lcr_i);
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    if (sample_pt) begin
                        shreg_q[idx_q] <= rx_s_i;
                        all_low_q      <= all_low_q & ~rx_s_i;
                        if (idx_q == last_bit_idx(cfg_q.len)) begin
                            state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
                        end else begin
                            idx_q <= idx_q + 3'd1;
                        end
                    end
                end
                ST_PAR: begin
                    if (sample_pt) begin
                        par_q     <= rx_s_i;
                        all_low_q <= all_low_q & ~rx_s_i;
                        state_q   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (sample_pt) begin
                        if (!rx_s_i) begin
                            valid_q       <= 1'b1;
                            res_q.data    <= shreg_q;
                            res_q.frm_err <= 1'b1;
                            res_q.brk     <= all_low_q;
                            res_q.par_err <= perr_w & ~all_low_q;
                            res_q.par_bit <= par_q;
                            state_q       <= all_low_q ? ST_HOLD : ST_IDLE;
                        end else if (cfg_q.long_stop && cfg_q.len == 2'b00) begin
                            state_q <= ST_STOP2;
                        end else begin
                            valid_q       <= 1'b1;
                            res_q.data    <= shreg_q;
                            res_q.par_err <= perr_w;
                            res_q.par_bit <= par_q;
                            state_q       <= ST_IDLE;
                        end
                    end
                end
                ST_STOP2: begin
                    if (sample_pt) begin
                        valid_q       <= 1'b1;
                        res_q.data    <= shreg_q;
                        res_q.frm_err <= ~rx_s_i;
                        res_q.par_err <= perr_w;
                        res_q.par_bit <= par_q;
                        state_q       <= ST_IDLE;
                    end
                end
                ST_HOLD: begin
                    if (rx_s_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign valid_o = valid_q;
    assign res_o   = res_q;

    // R10: strobe never lasts two clocks
    p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R1: bits above the configured length stay zero
    p_zero_ext_r1: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ((res_q.data >> (5 + int'(cfg_q.len))) == '0));

    // R2: no parity slot means no parity result
    p_no_parity_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !cfg_q.par_en) |-> (!res_q.par_err && !res_q.par_bit));

    // R4: forced mode flags an error exactly when the bit equals control bit 4
    p_forced_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_q && cfg_q.par_en && cfg_q.par_force && !res_q.brk)
            |-> (res_q.par_err == (res_q.par_bit == cfg_q.par_even)));

    // R9: after a break no word is reported while the line stays low
    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |=> !valid_q);
endmodule

// File: rtl/uart_line_rx.sv
module uart_line_rx
    import uart_lrx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic [5:0]        lcr_i,
    output logic              rx_valid_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              parity_err_o,
    output logic              frame_err_o,
    output logic              break_o,
    output logic              parity_bit_o
);
    logic       rx_s;
    rx_result_t res;

    uart_lrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(rx_i),
        .q_o(rx_s)
    );

    uart_lrx_fsm #(.OSR(OSR)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .rx_s_i (rx_s),
        .lcr_i  (lcr_i),
        .valid_o(rx_valid_o),
        .res_o  (res)
    );

    assign rx_data_o    = res.data;
    assign parity_err_o = res.par_err;
    assign frame_err_o  = res.frm_err;
    assign break_o      = res.brk;
    assign parity_bit_o = res.par_bit;

    // R10: outputs quiet between strobes
    p_quiet_between_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_o |-> (rx_data_o == '0 && !parity_err_o && !frame_err_o
                         && !break_o && !parity_bit_o));

    // R9: a break is always a framing error with a zero word
    p_break_fe_r9: assert property (@(posedge clk) disable iff (rst)
        break_o |-> (frame_err_o && rx_data_o == '0 && !parity_err_o));
endmodule

// File: tb/uart_line_rx_tb_top.sv
module uart_line_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx  = 1'b1;
    logic       tick;
    logic [5:0] lcr = '0;
    logic       v;
    logic [7:0] d;
    logic       pe, fe, bk, pb;

    int n_chk = 0;
    int n_bad = 0;
    int n_val = 0;
    int run_len = 0;
    int max_run = 0;
    int noisy = 0;
    bit timeout = 0;

    logic [7:0] c_d  [64];
    logic       c_pe [64];
    logic       c_fe [64];
    logic       c_bk [64];
    logic       c_pb [64];

    logic [1:0] tdiv = '0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick = (tdiv == 2'd3);

    uart_line_rx dut_i (
        .clk(clk), .rst(rst), .rx_i(rx), .tick_i(tick), .lcr_i(lcr),
        .rx_valid_o(v), .rx_data_o(d), .parity_err_o(pe),
        .frame_err_o(fe), .break_o(bk), .parity_bit_o(pb)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (v) begin
                c_d[n_val % 64]  = d;
                c_pe[n_val % 64] = pe;
                c_fe[n_val % 64] = fe;
                c_bk[n_val % 64] = bk;
                c_pb[n_val % 64] = pb;
                n_val = n_val + 1;
                run_len = run_len + 1;
                if (run_len > max_run) max_run = run_len;
            end else begin
                run_len = 0;
                if (d != 0 || pe || fe || bk || pb) noisy = noisy + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int ticks);
        rx = lvl;
        repeat (ticks * 4) @(negedge clk);
    endtask

    task automatic send(input int nb, input logic [7:0] dat, input bit has_p,
                        input logic pbit, input logic stop_lvl, input int stop_t);
        hold(1'b0, 16);
        for (int i = 0; i < nb; i++) hold(dat[i], 16);
        if (has_p) hold(pbit, 16);
        hold(stop_lvl, stop_t);
    endtask

    task automatic expect_one(input string req, input int n0, input int ed,
                              input int epe, input int efe, input int ebk, input int epb);
        chk({req, " count"}, n_val - n0, 1);
        chk({req, " data"}, int'(c_d[n0 % 64]), ed);
        chk({req, " parity_err"}, int'(c_pe[n0 % 64]), epe);
        chk({req, " frame_err"}, int'(c_fe[n0 % 64]), efe);
        chk({req, " break"}, int'(c_bk[n0 % 64]), ebk);
        chk({req, " parity_bit"}, int'(c_pb[n0 % 64]), epb);
    endtask

    task automatic t_reset;
        chk("R11 reset valid", int'(v), 0);
        chk("R11 reset data", int'(d), 0);
        chk("R11 reset flags", int'({pe, fe, bk, pb}), 0);
    endtask

    task automatic t_lengths;
        for (int l = 0; l < 4; l++) begin
            int n0 = n_val;
            logic [7:0] m = 8'hFF >> (3 - l);
            lcr = 6'(l);
            send(5 + l, 8'hB5, 0, 1'b0, 1'b1, 16);
            hold(1'b1, 32);
            expect_one("R1 length", n0, int'(8'hB5 & m), 0, 0, 0, 0);
        end
    endtask

    task automatic t_no_parity;
        int n0 = n_val;
        lcr = 6'b000011;
        send(8, 8'h81, 0, 1'b0, 1'b1, 16);
        hold(1'b1, 32);
        expect_one("R2 no parity", n0, 8'h81, 0, 0, 0, 0);
    endtask

    task automatic t_even_odd;
        int n0;
        lcr = 6'b011011;   // 8 bits, parity on, even
        n0 = n_val; send(8, 8'h35, 1, 1'b0, 1'b1, 16); hold(1'b1, 32);
        expect_one("R3 even ok", n0, 8'h35, 0, 0, 0, 0);
        n0 = n_val; send(8, 8'h35, 1, 1'b1, 1'b1, 16); hold(1'b1, 32);
        expect_one("R3 even bad", n0, 8'h35, 1, 0, 0, 1);
        lcr = 6'b001010;   // 7 bits, parity on, odd
        n0 = n_val; send(7, 8'h07, 1, 1'b0, 1'b1, 16); hold(1'b1, 32);
        expect_one("R3 odd ok", n0, 8'h07, 0, 0, 0, 0);
        n0 = n_val; send(7, 8'h07, 1, 1'b1, 1'b1, 16); hold(1'b1, 32);
        expect_one("R3 odd bad", n0, 8'h07, 1, 0, 0, 1);
    endtask

    task automatic t_forced;
        int n0;
        lcr = 6'b101011;   // forced, bit4 low: expect 1
        n0 = n_val; send(8, 8'h42, 1, 1'b1, 1'b1, 16); hold(1'b1, 32);
        expect_one("R4 forced hi ok", n0, 8'h42, 0, 0, 0, 1);
        n0 = n_val; send(8, 8'h42, 1, 1'b0, 1'b1, 16); hold(1'b1, 32);
        expect_one("R4 forced hi bad", n0, 8'h42, 1, 0, 0, 0);
        lcr = 6'b111011;   // forced, bit4 high: expect 0
        n0 = n_val; send(8, 8'h43, 1, 1'b0, 1'b1, 16); hold(1'b1, 32);
        expect_one("R4 forced lo ok", n0, 8'h43, 0, 0, 0, 0);
    endtask

    task automatic t_glitch;
        int n0 = n_val;
        lcr = 6'b000011;
        hold(1'b0, 3);
        hold(1'b1, 48);
        chk("R5 glitch ignored", n_val - n0, 0);
    endtask

    task automatic t_frame_err;
        int n0 = n_val;
        lcr = 6'b000011;
        send(8, 8'h5A, 0, 1'b0, 1'b0, 16);
        hold(1'b1, 40);
        expect_one("R6 framing", n0, 8'h5A, 0, 1, 0, 0);
    endtask

    task automatic t_long_stop;
        int n0;
        lcr = 6'b000100;   // 5 bits, long stop
        n0 = n_val; send(5, 8'h1B, 0, 1'b0, 1'b1, 24); hold(1'b1, 32);
        expect_one("R7 1.5 stop ok", n0, 8'h1B, 0, 0, 0, 0);
        n0 = n_val; send(5, 8'h0D, 0, 1'b0, 1'b1, 16);
        hold(1'b0, 6);
        hold(1'b1, 40);
        expect_one("R7 short stop", n0, 8'h0D, 0, 1, 0, 0);
    endtask

    task automatic t_stop_wide;
        int n0 = n_val;
        lcr = 6'b000111;   // 8 bits, stop bit 2 set
        send(8, 8'hC3, 0, 1'b0, 1'b1, 16);
        send(8, 8'h3C, 0, 1'b0, 1'b1, 16);
        hold(1'b1, 32);
        chk("R8 two words", n_val - n0, 2);
        chk("R8 first data", int'(c_d[n0 % 64]), 8'hC3);
        chk("R8 first fe", int'(c_fe[n0 % 64]), 0);
        chk("R8 second data", int'(c_d[(n0 + 1) % 64]), 8'h3C);
        chk("R8 second fe", int'(c_fe[(n0 + 1) % 64]), 0);
    endtask

    task automatic t_break;
        int n0 = n_val;
        lcr = 6'b011011;
        hold(1'b0, 16 * 14);
        expect_one("R9 break", n0, 0, 0, 1, 1, 0);
        hold(1'b1, 32);
        chk("R9 quiet until high", n_val - n0, 1);
        n0 = n_val;
        lcr = 6'b000011;
        send(8, 8'h96, 0, 1'b0, 1'b1, 16); hold(1'b1, 32);
        expect_one("R9 resume", n0, 8'h96, 0, 0, 0, 0);
    endtask

    task automatic run_all;
        repeat (6) @(negedge clk);
        t_reset();
        rst = 1'b0;
        hold(1'b1, 20);
        t_lengths();
        t_no_parity();
        t_even_odd();
        t_forced();
        t_glitch();
        t_frame_err();
        t_long_stop();
        t_stop_wide();
        t_break();
        chk("R10 strobe width", max_run, 1);
        chk("R10 quiet outputs", noisy, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual expired expected done");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule